// File: doc/BRIEF.md
# Multi-Device Flash Address Range Decoder

This block sits between a memory-mapped flash window and up to four attached flash devices. Software programs one upper-bound register per device slot. Each bound is the region base plus the combined size of that device and every slot before it. An incoming address is compared against these bounds. One cycle later the block returns a one-hot device select and the offset of the address inside the chosen device. An address outside every programmed slot raises an error flag instead.

The slots are numbered 0 to 3. They are checked in ascending order. Slot 0 starts at the region base. Every other slot starts at the bound of the slot before it and ends just below its own bound. A slot whose bound equals the bound before it has zero size, so it is never selected. This is how a system with fewer devices gives its unused slots no addresses. After reset every bound holds the region base, so all slots are empty and every lookup reports an error.

The response stage is a three-state machine:

- States:
  - ST_IDLE: no response this cycle.
  - ST_HIT: a slot was selected.
  - ST_MISS: the address matched no slot.
- Transitions, taken on every clock edge from any state:
  - To ST_HIT when a request arrives whose address falls in a slot.
  - To ST_MISS when a request arrives whose address falls in no slot.
  - To ST_IDLE when no request arrives.
- Reset puts the machine in ST_IDLE.

Top module: `flash_range_decoder`

## Requirements
- R1: After reset, rsp_valid is 0 and every slot bound equals the region base (default 0x100). Every address then yields rsp_err=1 and rsp_sel=0.
- R2: rsp_valid is 1 in exactly the cycle after the one in which req_valid was 1. When rsp_valid is 0, rsp_sel is 0 and rsp_err is 0.
- R3: A valid, in-range response carries exactly one set bit in rsp_sel. Bit i stands for slot i. Slot i is selected when start_i <= address < bound_i. Here start_0 is the region base and start_i is bound_(i-1).
- R4: A slot whose bound equals the previous bound (or the region base, for slot 0) is never selected, for any address.
- R5: rsp_offset equals the request address minus the start of the selected slot.
- R6: An address below the region base, or at or above the end of every slot, gives rsp_err=1, rsp_sel=0 and rsp_offset=0.
- R7: When programmed bounds make two slot ranges overlap, the lowest-numbered slot wins.
- R8: A bound write takes effect for requests in the following cycle onward. A request in the same cycle as the write is decoded against the old bound.
- R9: A write with wr_en=1 loads wr_top into the bound of slot wr_slot, where wr_slot=0..3 selects slots 0..3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bound register write strobe |
| wr_slot | input | 2 | Slot whose bound is written |
| wr_top | input | ADDR_W | New bound value (exclusive end address) |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Flat address to decode |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_sel | output | NUM_SLOTS | One-hot device select |
| rsp_offset | output | ADDR_W | Address offset inside the selected device |
| rsp_err | output | 1 | Address matched no slot |

## Verification
A bound write and a lookup can land in the same cycle. In that case the lookup must see the bound as it stood before the write. The bench provokes this by driving a write to slot 0 and a request inside the region the write will move, on the same clock edge. It then judges the result by the select and offset expected under the old bounds. A second request to the same address, one cycle later, must follow the new bounds. The rest of the bench sweeps every address of a 12-bit space under ascending, zero-size and overlapping bound sets, and compares each response with an arithmetic model.

// File: rtl/flash_dec_pkg.sv
package flash_dec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } dec_state_e;
endpackage

// File: rtl/flash_top_regs.sv
module flash_top_regs #(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned NUM_SLOTS   = 4,
    parameter int unsigned REGION_BASE = 'h100,
    localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [SLOT_W-1:0]                wr_slot,
    input  logic [ADDR_W-1:0]                wr_top,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0] tops
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(REGION_BASE);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_top
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tops[g] <= BASE_V;
            end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
                tops[g] <= wr_top;
            end
        end
    end
endmodule

// File: rtl/flash_slot_cmp.sv
module flash_slot_cmp #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              in_rng,
    output logic [ADDR_W-1:0] offset
);
    // Half-open window [lo, hi); an empty or inverted window never matches.
    assign in_rng = (addr >= lo) && (addr < hi);
    assign offset = addr - lo;
endmodule

// File: rtl/flash_slot_pick.sv
module flash_slot_pick #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS-1:0]             in_rng,
    input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] offs,
    output logic [NUM_SLOTS-1:0]             sel,
    output logic [ADDR_W-1:0]                off,
    output logic                             any
);
    always_comb begin
        sel = '0;
        off = '0;
        any = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (in_rng[i] && !any) begin
                sel[i] = 1'b1;
                off    = offs[i];
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/flash_range_decoder.sv
module flash_range_decoder
    import flash_dec_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned NUM_SLOTS   = 4,
    parameter int unsigned REGION_BASE = 'h100,
    localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic [ADDR_W-1:0]    wr_top,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic [NUM_SLOTS-1:0] rsp_sel,
    output logic [ADDR_W-1:0]    rsp_offset,
    output logic                 rsp_err
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(REGION_BASE);

    logic [NUM_SLOTS-1:0][ADDR_W-1:0] tops;
    logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_off;
    logic [NUM_SLOTS-1:0]             slot_hit;
    logic [NUM_SLOTS-1:0]             pick_sel;
    logic [ADDR_W-1:0]                pick_off;
    logic                             pick_any;

    dec_state_e           state, state_nx;
    logic [NUM_SLOTS-1:0] sel_q;
    logic [ADDR_W-1:0]    off_q;

    flash_top_regs #(
        .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .REGION_BASE(REGION_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_slot(wr_slot), .wr_top(wr_top), .tops(tops)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [ADDR_W-1:0] lo;
        if (g == 0) begin : g_first
            assign lo = BASE_V;
        end else begin : g_next
            assign lo = tops[g-1];
        end
        flash_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .addr(req_addr), .lo(lo), .hi(tops[g]),
            .in_rng(slot_hit[g]), .offset(slot_off[g])
        );
    end

    flash_slot_pick #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_pick (
        .in_rng(slot_hit), .offs(slot_off),
        .sel(pick_sel), .off(pick_off), .any(pick_any)
    );

    // Next-state logic
    always_comb begin
        if (!req_valid)    state_nx = ST_IDLE;
        else if (pick_any) state_nx = ST_HIT;
        else               state_nx = ST_MISS;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Captured decode result
    always_ff @(posedge clk) begin
        if (!rst_n || !(req_valid && pick_any)) begin
            sel_q <= '0;
            off_q <= '0;
        end else begin
            sel_q <= pick_sel;
            off_q <= pick_off;
        end
    end

    // Output decode
    always_comb begin
        rsp_valid  = 1'b0;
        rsp_err    = 1'b0;
        rsp_sel    = '0;
        rsp_offset = '0;
        unique case (state)
            ST_IDLE: ;
            ST_HIT: begin
                rsp_valid  = 1'b1;
                rsp_sel    = sel_q;
                rsp_offset = off_q;
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_range_decoder_chk.sv
module flash_range_decoder_chk #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_SLOTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 rsp_valid,
    input logic [NUM_SLOTS-1:0] rsp_sel,
    input logic [ADDR_W-1:0]    rsp_offset,
    input logic                 rsp_err
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2
    no_resp_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_sel == '0) && !rsp_err);

    // R3
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> ($countones(rsp_sel) == 1));

    // R6
    miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_sel == '0) && (rsp_offset == '0));
endmodule

bind flash_range_decoder flash_range_decoder_chk #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
    .rsp_sel(rsp_sel), .rsp_offset(rsp_offset), .rsp_err(rsp_err)
);

// File: tb/flash_range_decoder_tb.sv
module flash_range_decoder_tb;
    localparam int AW   = 12;
    localparam int NS   = 4;
    localparam int BASE = 'h100;
    localparam int SPAN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_slot = '0;
    logic [AW-1:0] wr_top = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [NS-1:0] rsp_sel;
    logic [AW-1:0] rsp_offset;
    logic          rsp_err;

    int checks = 0;
    int errors = 0;
    int m_top [NS];
    int hits  [NS];
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_range_decoder #(.ADDR_W(AW), .NUM_SLOTS(NS), .REGION_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot), .wr_top(wr_top),
        .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_sel(rsp_sel), .rsp_offset(rsp_offset), .rsp_err(rsp_err)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Packed word: bit17 valid, bit16 err, bits15:12 select, bits11:0 offset
    function automatic int expect_word(int a);
        int start = BASE;
        for (int i = 0; i < NS; i++) begin
            if (a >= start && a < m_top[i])
                return (1 << 17) | (1 << (12 + i)) | (a - start);
            start = m_top[i];
        end
        return (1 << 17) | (1 << 16);
    endfunction

    function automatic int dut_word();
        return int'({rsp_valid, rsp_err, rsp_sel, rsp_offset});
    endfunction

    task automatic set_top(int slot, int val);
        @(negedge clk);
        wr_en = 1'b1; wr_slot = 2'(slot); wr_top = AW'(val);
        @(negedge clk);
        wr_en = 1'b0;
        m_top[slot] = val;
    endtask

    // Back-to-back requests; each response checked one cycle after its request
    task automatic sweep(string tag);
        int prev = 0;
        for (int i = 0; i < NS; i++) hits[i] = 0;
        for (int a = 0; a <= SPAN; a++) begin
            @(negedge clk);
            if (a > 0) begin
                check(tag, dut_word(), expect_word(prev));
                for (int i = 0; i < NS; i++) if (rsp_sel[i]) hits[i]++;
            end
            if (a < SPAN) begin
                req_valid = 1'b1; req_addr = AW'(a);
            end else begin
                req_valid = 1'b0;
            end
            prev = a;
        end
        @(negedge clk);
        check("R2 idle after requests", int'(rsp_valid), 0);
    endtask

    task automatic lookup(string tag, int a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, dut_word(), expect_word(a));
    endtask

    initial begin
        for (int i = 0; i < NS; i++) m_top[i] = BASE;
        repeat (3) @(negedge clk);
        check("R1 no response in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 no response after reset", int'(rsp_valid), 0);
        sweep("R1 reset bounds all miss");

        // Ascending layout
        set_top(0, 'h300); set_top(1, 'h500); set_top(2, 'h900); set_top(3, 'hC00);
        sweep("R3 R5 R6 R9 ascending");
        check("R3 slot0 count", hits[0], 'h200);
        check("R3 slot3 count", hits[3], 'h300);
        lookup("R6 below base", 'h0FF);
        lookup("R6 at last bound", 'hC00);
        lookup("R5 first of slot2", 'h500);
        lookup("R5 last of slot2", 'h8FF);

        // R8: write and request in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_slot = 2'd0; wr_top = AW'('h200);
        req_valid = 1'b1; req_addr = AW'('h250);
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 same-cycle uses old bound", dut_word(),
              (1 << 17) | (1 << 12) | 'h150);
        @(negedge clk);
        req_valid = 1'b0;
        m_top[0] = 'h200;
        check("R8 next request uses new bound", dut_word(),
              (1 << 17) | (1 << 13) | 'h50);

        // Zero-size slots 1 and 3
        set_top(0, 'h400); set_top(1, 'h400); set_top(2, 'hA00); set_top(3, 'hA00);
        sweep("R4 zero-size layout");
        check("R4 empty slot1 never selected", hits[1], 0);
        check("R4 empty slot3 never selected", hits[3], 0);
        check("R4 slot2 takes range", hits[2], 'h600);

        // Overlapping layout: slot2 window [0x300,0x800) overlaps slot0
        set_top(0, 'h600); set_top(1, 'h300); set_top(2, 'h800); set_top(3, 'hF00);
        sweep("R7 overlapping layout");
        check("R7 overlap goes to slot0", hits[0], 'h500);
        check("R7 slot2 keeps remainder", hits[2], 'h200);
        lookup("R7 overlap point", 'h400);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule